// File: doc/BRIEF.md
# Base-Limit Access Guard

This block sits beside a processor's memory port and judges every access against one permitted window. The window is described by two registers. The first holds the lowest physical address the unprivileged program may reach. The second holds the window's size, not its last address. For an access from user mode, the block returns a grant when the address lies in `[base, base + size)` and returns a fault otherwise. An access made in kernel mode is granted wherever it points. The block only decides. It never carries data, and the handling of a fault is left to the surrounding core.

The two window registers are loaded through a small configuration port. That port accepts a write only while the core is in kernel mode. An attempted write from user mode leaves both registers as they were and raises a one-cycle privilege-violation flag. After reset both registers are zero, so user mode starts with no reachable memory until the kernel opens a window.

Top module: `bl_guard`

## Requirements
- R1: After reset, the window start and the window size are both zero, and every user-mode access is refused with `acc_fault`.
- R2: A valid user-mode access is granted exactly when `base <= addr < base + size`. The sum is taken one bit wider than the address, so a window that ends at the top of the address space does not wrap around to address zero. A size of zero grants nothing.
- R3: A valid access with `priv_kernel` = 1 is always granted, whatever the window registers hold.
- R4: While `acc_valid` is high, exactly one of `acc_grant` and `acc_fault` is high, in the same cycle as the request. While `acc_valid` is low, both are low.
- R5: When `cfg_we` = 1 and `priv_kernel` = 1, `cfg_data` is loaded at the clock edge into the window start if `cfg_sel` = 0, or into the window size if `cfg_sel` = 1. Accesses from the following cycle onward are judged against the new value.
- R6: A configuration write with `priv_kernel` = 0 changes neither the window start nor the window size.
- R7: A configuration write with `priv_kernel` = 0 sets `cfg_fault` high for exactly the next cycle. A kernel-mode write, or no write, leaves `cfg_fault` low in the next cycle.
- R8: The direction flag `acc_write` has no effect on the decision. A read and a write to the same address in the same mode get the same answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_write | input | 1 | 1 = store, 0 = load |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| cfg_we | input | 1 | Configuration write request |
| cfg_sel | input | 1 | 0 = window start, 1 = window size |
| cfg_data | input | ADDR_W | Value to load |
| acc_grant | output | 1 | Access permitted |
| acc_fault | output | 1 | Access refused (protection fault) |
| cfg_fault | output | 1 | Privilege violation on the previous cycle's configuration write |

## Verification
The bench builds the guard with `ADDR_W` = 8, so the whole address space has only 256 addresses. At that width the bench can sweep every address after reset and around each window edge. It can also place a window whose end equals 256, which exercises the carry bit that stops the window from wrapping around. A behavioural model that holds the window as plain integers predicts grant, fault and the privilege-violation flag on every cycle. The model follows the bench through directed phases and a long random phase that mixes both privilege modes with configuration writes.

// File: rtl/bl_guard.sv
module bl_guard #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              priv_kernel,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  output logic              acc_grant,
  output logic              acc_fault,
  output logic              cfg_fault
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] base_q, size_q;
  logic [SUM_W-1:0]  win_end;
  logic              in_win, allow, cfg_ok;

  assign win_end   = {1'b0, base_q} + {1'b0, size_q};
  assign in_win    = (acc_addr >= base_q) && ({1'b0, acc_addr} < win_end);
  assign allow     = priv_kernel | in_win;
  assign acc_grant = acc_valid & allow;
  assign acc_fault = acc_valid & ~allow;
  assign cfg_ok    = cfg_we & priv_kernel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      size_q    <= '0;
      cfg_fault <= 1'b0;
    end else begin
      cfg_fault <= cfg_we & ~priv_kernel;
      if (cfg_ok && !cfg_sel) base_q <= cfg_data;
      if (cfg_ok && cfg_sel)  size_q <= cfg_data;
    end
  end

  AST_ONE_HOT_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_grant ^ acc_fault)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_grant && !acc_fault)); // R4
  AST_KERNEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && priv_kernel) |-> acc_grant); // R3
  AST_USER_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv_kernel) |=> ($stable(base_q) && $stable(size_q))); // R6
  AST_PRIV_FLAG_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv_kernel) |=> cfg_fault); // R7
  AST_PRIV_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !priv_kernel) |=> !cfg_fault); // R7
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !priv_kernel && size_q == '0) |-> acc_fault); // R2
  AST_DIR_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |-> (acc_grant || acc_fault)); // R8
endmodule

// File: tb/bl_guard_tb_top.sv
`timescale 1ns/100ps
module bl_guard_tb_top;
  localparam int AW = 8;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, priv_kernel = 0, cfg_we = 0, cfg_sel = 0;
  logic [AW-1:0] acc_addr = '0, cfg_data = '0;
  logic acc_grant, acc_fault, cfg_fault;

  int errors = 0, checks = 0;
  int m_base = 0, m_size = 0;
  bit m_pend = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bl_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .priv_kernel(priv_kernel), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .acc_grant(acc_grant),
    .acc_fault(acc_fault), .cfg_fault(cfg_fault));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int a, bit w, bit k, bit we, bit sel, int d, string tag);
    string t;
    bit eg, ef;
    acc_valid = v; acc_addr = AW'(a); acc_write = w; priv_kernel = k;
    cfg_we = we; cfg_sel = sel; cfg_data = AW'(d);
    #1;
    eg = v && (k || (a >= m_base && a < m_base + m_size));
    ef = v && !eg;
    t = tag;
    if (t == "") t = !v ? "R4" : (k ? "R3" : "R2");
    chk(t, "grant", int'(acc_grant), int'(eg));
    chk(t, "fault", int'(acc_fault), int'(ef));
    chk("R7", "cfg_fault", int'(cfg_fault), int'(m_pend));
    @(posedge clk);
    m_pend = we && !k;
    if (we && k) begin
      if (sel) m_size = d; else m_base = d;
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing reachable in user mode after reset
    for (int a = 0; a < SPAN; a++) step(1, a, a[0], 0, 0, 0, 0, "R1");
    // R4: idle cycles
    for (int i = 0; i < 4; i++) step(0, i * 37, 0, i[0], 0, 0, 0, "R4");
    // R5: kernel loads window 0x40..0x4F
    step(0, 0, 0, 1, 1, 0, 'h40, "R5");
    step(1, 'h40, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 1, 1, 'h10, "R5");
    for (int a = 'h3E; a <= 'h51; a++) step(1, a, 0, 0, 0, 0, 0, "R5");
    // R8: read and write to same address agree
    for (int a = 'h3F; a <= 'h50; a++) begin
      step(1, a, 0, 0, 0, 0, 0, "R8");
      step(1, a, 1, 0, 0, 0, 0, "R8");
    end
    // R6 / R7: user attempts to widen window
    step(1, 'h45, 0, 0, 1, 0, 'h00, "R6");
    step(1, 'h00, 0, 0, 1, 1, 'hFF, "R6");
    step(1, 'h30, 1, 0, 0, 0, 0, "R6");
    step(1, 'h4F, 1, 0, 0, 0, 0, "R6");
    step(1, 'h50, 1, 0, 0, 0, 0, "R6");
    // R3: kernel reaches everything
    for (int a = 0; a < SPAN; a += 7) step(1, a, a[1], 1, 0, 0, 0, "R3");
    // R2: window touching the top of memory, no wrap
    step(0, 0, 0, 1, 1, 0, 'hF0, "R2");
    step(0, 0, 0, 1, 1, 1, 'h10, "R2");
    for (int a = 'hEE; a < SPAN; a++) step(1, a, 0, 0, 0, 0, 0, "R2");
    for (int a = 0; a < 4; a++) step(1, a, 0, 0, 0, 0, 0, "R2");
    // R2: empty window
    step(0, 0, 0, 1, 1, 1, 0, "R2");
    for (int a = 'hEE; a < SPAN; a++) step(1, a, 0, 0, 0, 0, 0, "R2");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit k, we;
      k  = ($urandom % 4) == 0;
      we = ($urandom % 8) == 0;
      step(($urandom % 5) != 0, $urandom % SPAN, $urandom % 2, k, we,
           $urandom % 2, $urandom % SPAN, "");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule